// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block times the cycles of an external memory bus that is divided into eight address areas. When the bus is idle it takes a request that carries an area number, a read/write flag and the current configuration. It then steps through a short sequence of bus states and reports the state it is in. It raises a strobe during the last state of the access and pulses a done flag one clock later. Driving the address and data lines, decoding chip selects and any DRAM timing are handled elsewhere.

The areas fall into two groups:

- **Areas 1, 3, 4, 5 and 7.**
  - A read whose per-area wait-enable bit is clear lasts one state.
  - A read whose bit is set, and every write, lasts two states plus any wait states requested on the external active-low wait pin.
- **Areas 0, 2 and 6.**
  - Every access adds a programmable number of long-wait states after the first state. A shared 2-bit code sets this number.
  - The wait pin may extend the access further after the long waits. This applies to writes, and to reads whose enable bit is set.

Area 3 shares its wait pin with another function, so the pin is always treated as inactive for area 3. The wait pin passes through a two-flop synchronizer before the controller looks at it.

Top module: `ebus_wait_ctrl`

## Requirements
- R1: A request is accepted only on a clock edge where `busy` is low and `req_valid` is high. In the next cycle, `busy` is 1 and `phase` is 1. While busy, `req_valid` and changes to area, direction, `wait_en` and `long_code` have no effect on the running access, because all of them are captured at acceptance.
- R2: For areas 1, 3, 4, 5 and 7, a read whose bit `wait_en[area]` is 0 lasts exactly one state. `phase` is 1 in that state, `last_state` is high in it, and the wait pin is ignored.
- R3: For areas 1, 3, 4, 5 and 7, a read with `wait_en[area]` = 1, or any write, lasts two states plus W wait states. `phase` runs 1, then 3 for each of the W wait states, then 4.
- R4: The pin is looked at on the clock edge that would start the final state. The level used there is the one `wait_pin_n` held two rising edges earlier, because of the synchronizer. A low level inserts a wait state and the check repeats on each later edge. The first high level seen moves the access to the final state.
- R5: For areas 0, 2 and 6, the access lasts 1 + L states when the pin is not used, where L = `long_code` + 1 (codes 0 to 3 give 1 to 4 long-wait states). `phase` runs 1, then 2 for L − 1 states, then 4. The pin is not used for reads whose `wait_en[area]` is 0.
- R6: For areas 0, 2 and 6, a write or a read with `wait_en[area]` = 1 adds pin wait states (`phase` 3) after the long-wait states, before the final state.
- R7: An area 3 access never enters a pin wait state: the wait pin is treated as high. An area 3 write lasts exactly two states.
- R8: `last_state` is high in exactly one cycle of each access, the last one. In the following cycle `busy` is 0 and `done` is 1 for exactly that one cycle.
- R9: After reset, `busy`, `last_state` and `done` are 0 and `phase` is 0. The phase code is 0 for idle, 1 for the first state, 2 for a long wait, 3 for a pin wait, and 4 for the final state of a multi-state access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_area | input | 3 | Area number 0 to 7 |
| req_write | input | 1 | 1 = write, 0 = read |
| wait_en | input | 8 | Per-area wait-enable bits, bit n for area n |
| long_code | input | 2 | Shared long-wait code; L = code + 1 |
| wait_pin_n | input | 1 | External wait request, active low, asynchronous |
| busy | output | 1 | An access is in progress |
| phase | output | 3 | Current bus state code (see R9) |
| last_state | output | 1 | High during the final state of an access |
| done | output | 1 | One-clock pulse after the final state |

## Verification
The bound checker checks the following on every cycle:
- An accepted request always opens with phase 1.
- A one-state read strobes immediately.
- Long-wait states occur only in the long group.
- A pin wait appears only when the captured plan allows the pin and never for area 3.
- A held-low synchronized pin keeps the access waiting.
- `done` follows the final state once with the bus idle.

The total length of each access cannot be seen cycle by cycle. This covers how many long waits each code yields, how many wait states a given pin waveform produces after the two-edge synchronizer delay, and whether configuration changed mid-access is really ignored. Only the bench scenarios show these, by comparing the whole phase sequence against lengths computed from the requirements.

// File: rtl/ebw_pkg.sv
package ebw_pkg;

  // Bus state codes as seen on the phase output.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FIRST = 3'd1,
    PH_LONG  = 3'd2,
    PH_PIN   = 3'd3,
    PH_LAST  = 3'd4
  } phase_e;

  // Decisions taken once, when an access is accepted.
  typedef struct packed {
    logic long_grp;   // area belongs to the long-wait group
    logic two_state;  // short-group access that needs a second state
    logic use_pin;    // wait pin is consulted before the final state
  } plan_t;

  // Number of long-wait states for a code value.
  function automatic int long_states(input int code);
    return code + 1;
  endfunction

  // Minimum length of an access with no pin wait states inserted.
  function automatic int base_states(input plan_t p, input int code);
    if (p.long_grp)
      return 1 + long_states(code);
    else if (p.two_state)
      return 2;
    else
      return 1;
  endfunction

endpackage

// File: rtl/ebw_pin_sync.sv
module ebw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_n_sync
);

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic q;
      if (g == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= 1'b1;
          else        q <= pin_n;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= 1'b1;
          else        q <= g_stage[g-1].q;
        end
      end
    end
  endgenerate

  assign pin_n_sync = g_stage[STAGES-1].q;

endmodule

// File: rtl/ebw_access_plan.sv
module ebw_access_plan
  import ebw_pkg::*;
#(
  parameter int                  NUM_AREAS  = 8,
  parameter int                  AREA_W     = 3,
  parameter logic [NUM_AREAS-1:0] LONG_MASK  = 8'b0100_0101,
  parameter logic [NUM_AREAS-1:0] NOPIN_MASK = 8'b0000_1000
) (
  input  logic [AREA_W-1:0]    area,
  input  logic                 is_write,
  input  logic [NUM_AREAS-1:0] en_bits,
  output plan_t                plan
);

  logic en_sel;
  logic in_long;
  logic pin_ok;
  logic wants_wait;

  assign en_sel     = en_bits[area];
  assign in_long    = LONG_MASK[area];
  assign pin_ok     = ~NOPIN_MASK[area];
  // Writes ignore the enable bit and always allow waiting.
  assign wants_wait = is_write | en_sel;

  always_comb begin
    plan.long_grp  = in_long;
    plan.two_state = ~in_long & wants_wait;
    plan.use_pin   = wants_wait & pin_ok;
  end

endmodule

// File: rtl/ebw_long_counter.sv
module ebw_long_counter #(
  parameter int LW_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LW_W-1:0] load_val,
  input  logic            dec,
  output logic            is_zero,
  output logic            is_one
);

  logic [LW_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (dec && (cnt != '0))
      cnt <= cnt - 1'b1;
  end

  assign is_zero = (cnt == '0);
  assign is_one  = (cnt == LW_W'(1));

endmodule

// File: rtl/ebw_sequencer.sv
module ebw_sequencer
  import ebw_pkg::*;
#(
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [AREA_W-1:0] req_area,
  input  plan_t             plan_in,
  input  logic              lw_zero,
  input  logic              lw_one,
  input  logic              pin_low,
  output phase_e            ph,
  output plan_t             plan_q,
  output logic [AREA_W-1:0] area_q,
  output logic              accept_evt,
  output logic              gate_evt,
  output logic              lw_dec,
  output logic              final_strobe,
  output logic              done
);

  phase_e ph_nx;
  logic   single_state;

  assign accept_evt   = (ph == PH_IDLE) && req_valid;
  assign lw_dec       = (ph == PH_LONG);
  assign single_state = (ph == PH_FIRST) && !plan_q.long_grp && !plan_q.two_state;
  assign final_strobe = (ph == PH_LAST) || single_state;

  // gate_evt marks the edge that would start the final state; the
  // synchronized wait pin is consulted only there and in pin waits.
  always_comb begin
    ph_nx    = ph;
    gate_evt = 1'b0;
    unique case (ph)
      PH_IDLE:  if (req_valid) ph_nx = PH_FIRST;
      PH_FIRST: begin
        if (plan_q.long_grp) begin
          if (lw_zero) gate_evt = 1'b1;
          else         ph_nx    = PH_LONG;
        end else if (plan_q.two_state) begin
          gate_evt = 1'b1;
        end else begin
          ph_nx = PH_IDLE;
        end
      end
      PH_LONG:  if (lw_one) gate_evt = 1'b1;
      PH_PIN:   if (!pin_low) ph_nx = PH_LAST;
      PH_LAST:  ph_nx = PH_IDLE;
      default:  ph_nx = PH_IDLE;
    endcase
    if (gate_evt)
      ph_nx = (plan_q.use_pin && pin_low) ? PH_PIN : PH_LAST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      plan_q <= '0;
      area_q <= '0;
      done   <= 1'b0;
    end else begin
      ph   <= ph_nx;
      done <= final_strobe;
      if (accept_evt) begin
        plan_q <= plan_in;
        area_q <= req_area;
      end
    end
  end

endmodule

// File: rtl/ebus_wait_ctrl.sv
module ebus_wait_ctrl
  import ebw_pkg::*;
#(
  parameter int                   NUM_AREAS   = 8,
  parameter int                   LW_W        = 2,
  parameter int                   SYNC_STAGES = 2,
  parameter logic [NUM_AREAS-1:0] LONG_MASK   = 8'b0100_0101,
  parameter logic [NUM_AREAS-1:0] NOPIN_MASK  = 8'b0000_1000,
  localparam int                  AREA_W      = $clog2(NUM_AREAS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [AREA_W-1:0]    req_area,
  input  logic                 req_write,
  input  logic [NUM_AREAS-1:0] wait_en,
  input  logic [LW_W-1:0]      long_code,
  input  logic                 wait_pin_n,
  output logic                 busy,
  output logic [2:0]           phase,
  output logic                 last_state,
  output logic                 done
);

  // Named internal events, used by the bound checker.
  logic              pin_n_sync;
  logic              pin_low_s;
  plan_t             plan_req;
  plan_t             plan_cur;
  phase_e            ph;
  logic [AREA_W-1:0] cur_area;
  logic              accept_evt;
  logic              gate_evt;
  logic              lw_dec;
  logic              lw_zero;
  logic              lw_one;
  logic              final_strobe;
  logic              cur_long;
  logic              cur_two;
  logic              cur_pin;

  ebw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_n      (wait_pin_n),
    .pin_n_sync (pin_n_sync)
  );

  assign pin_low_s = ~pin_n_sync;

  ebw_access_plan #(
    .NUM_AREAS  (NUM_AREAS),
    .AREA_W     (AREA_W),
    .LONG_MASK  (LONG_MASK),
    .NOPIN_MASK (NOPIN_MASK)
  ) u_plan (
    .area     (req_area),
    .is_write (req_write),
    .en_bits  (wait_en),
    .plan     (plan_req)
  );

  ebw_long_counter #(.LW_W(LW_W)) u_lw (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_evt),
    .load_val (long_code),
    .dec      (lw_dec),
    .is_zero  (lw_zero),
    .is_one   (lw_one)
  );

  ebw_sequencer #(.AREA_W(AREA_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_area     (req_area),
    .plan_in      (plan_req),
    .lw_zero      (lw_zero),
    .lw_one       (lw_one),
    .pin_low      (pin_low_s),
    .ph           (ph),
    .plan_q       (plan_cur),
    .area_q       (cur_area),
    .accept_evt   (accept_evt),
    .gate_evt     (gate_evt),
    .lw_dec       (lw_dec),
    .final_strobe (final_strobe),
    .done         (done)
  );

  assign cur_long   = plan_cur.long_grp;
  assign cur_two    = plan_cur.two_state;
  assign cur_pin    = plan_cur.use_pin;

  assign busy       = (ph != PH_IDLE);
  assign phase      = ph;
  assign last_state = final_strobe;

endmodule

// File: rtl/ebw_checker.sv
module ebw_checker #(
  parameter int                   NUM_AREAS  = 8,
  parameter int                   AREA_W     = 3,
  parameter logic [NUM_AREAS-1:0] NOPIN_MASK = 8'b0000_1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [2:0]        phase,
  input logic              last_state,
  input logic              done,
  input logic              accept_evt,
  input logic              cur_long,
  input logic              cur_two,
  input logic              cur_pin,
  input logic [AREA_W-1:0] cur_area,
  input logic              pin_low_s
);

  AST_ACCEPT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (busy && phase == 3'd1)); // R1

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_state) |=> busy); // R1

  AST_ONE_STATE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && !cur_long && !cur_two) |-> last_state); // R2

  AST_SHORT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && !cur_long && cur_two) |=> (phase == 3'd3 || phase == 3'd4)); // R3

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 && pin_low_s) |=> (phase == 3'd3)); // R4

  AST_LONG_ONLY_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2) |-> cur_long); // R5

  AST_PIN_NEEDS_PLAN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3) |-> cur_pin); // R6

  AST_NOPIN_AREA: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3) |-> !NOPIN_MASK[cur_area]); // R7

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_state |=> (!busy && done)); // R8

  AST_DONE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(last_state) && !busy)); // R8

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase <= 3'd4) && (busy == (phase != 3'd0))); // R9

endmodule

bind ebus_wait_ctrl ebw_checker #(
  .NUM_AREAS  (NUM_AREAS),
  .AREA_W     (AREA_W),
  .NOPIN_MASK (NOPIN_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .phase      (phase),
  .last_state (last_state),
  .done       (done),
  .accept_evt (accept_evt),
  .cur_long   (cur_long),
  .cur_two    (cur_two),
  .cur_pin    (cur_pin),
  .cur_area   (cur_area),
  .pin_low_s  (pin_low_s)
);

// File: tb/ebus_wait_ctrl_test.sv
`timescale 1ns/1ps
module ebus_wait_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_area = '0;
  logic       req_write = 1'b0;
  logic [7:0] wait_en = '0;
  logic [1:0] long_code = '0;
  logic       wait_pin_n = 1'b1;
  logic       busy;
  logic [2:0] phase;
  logic       last_state;
  logic       done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit pat [0:63];

  always #10 clk = ~clk;

  ebus_wait_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_area   (req_area),
    .req_write  (req_write),
    .wait_en    (wait_en),
    .long_code  (long_code),
    .wait_pin_n (wait_pin_n),
    .busy       (busy),
    .phase      (phase),
    .last_state (last_state),
    .done       (done)
  );

  task automatic chk(input string tag, input int act, input int exp_v);
    n_cmp++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  // pat[k] is the pin level driven for the edge k-2 relative to acceptance.
  task automatic gen_pat(input int kind);
    for (int j = 0; j < 64; j++) pat[j] = 1'b1;
    if (kind == 1) begin
      int st = $urandom_range(0, 6);
      int ln = $urandom_range(1, 8);
      for (int j = st; j < st + ln; j++) pat[j] = 1'b0;
    end else if (kind == 2) begin
      for (int j = 0; j < 20; j++) pat[j] = ($urandom_range(0, 2) != 0);
    end else if (kind == 3) begin
      for (int j = 0; j < 20; j++) pat[j] = 1'b0;
    end
  endtask

  // Consecutive low levels seen from the decision edge s on (R4).
  function automatic int exp_waits(input int s);
    int w = 0;
    while (pat[s + w] == 1'b0) w++;
    return w;
  endfunction

  function automatic bit area_long(input int a);
    return (a == 0) || (a == 2) || (a == 6);
  endfunction

  // Phase code expected in cycle c of an access (R3, R5, R6, R9 encoding).
  function automatic int exp_phase(input int c, input int n, input bit lg, input int lcnt, input int w);
    if (c == 0) return 1;
    if (lg && c < lcnt) return 2;
    if (c < n - 1) return 3;
    return 4;
  endfunction

  task automatic run_txn(input int a, input bit wr, input logic [7:0] en, input int code, input bit hold);
    bit    lg    = area_long(a);
    bit    enb   = en[a];
    bit    waits = wr || enb;
    int    lcnt  = code + 1;
    int    w     = 0;
    int    n;
    string tag;
    if (lg) begin
      w   = waits ? exp_waits(lcnt) : 0;
      n   = 1 + lcnt + w;
      tag = waits ? "R6" : "R5";
    end else if (!waits) begin
      n   = 1;
      tag = "R2";
    end else begin
      w   = (a != 3) ? exp_waits(1) : 0;
      n   = 2 + w;
      tag = (a == 3) ? "R7" : "R3";
    end
    if (w > 0) tag = {tag, " R4"};
    if (hold)  tag = {tag, " R1"};
    for (int i = 0; i < n + 4; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        int c = i - 3;
        if (c < n) begin
          chk({tag, " busy"}, busy, 1);
          chk({tag, " phase"}, phase, exp_phase(c, n, lg, lcnt, w));
          chk({tag, " R8 last_state"}, last_state, (c == n - 1) ? 1 : 0);
          chk({tag, " R8 done low"}, done, 0);
        end else begin
          chk({tag, " R8 idle after"}, busy, 0);
          chk({tag, " R8 done pulse"}, done, 1);
          chk({tag, " R8 phase idle"}, phase, 0);
        end
      end
      wait_pin_n = pat[i];
      if (i == 2) begin
        req_valid = 1'b1;
        req_area  = 3'(a);
        req_write = wr;
        wait_en   = en;
        long_code = 2'(code);
      end else if (i == 3 && hold) begin
        req_area  = 3'($urandom_range(0, 7));
        req_write = 1'($urandom_range(0, 1));
        wait_en   = 8'($urandom_range(0, 255));
        long_code = 2'($urandom_range(0, 3));
      end else if (!hold || i >= n + 3) begin
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R8 done single pulse", done, 0);
    wait_pin_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R9 busy in reset", busy, 0);
    chk("R9 phase in reset", phase, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 busy after reset", busy, 0);
    chk("R9 phase after reset", phase, 0);
    chk("R9 last_state after reset", last_state, 0);
    chk("R9 done after reset", done, 0);

    // Directed sweep: every area, direction, enable and code.
    for (int a = 0; a < 8; a++)
      for (int wr = 0; wr < 2; wr++)
        for (int e = 0; e < 2; e++)
          for (int code = 0; code < 4; code++) begin
            gen_pat((a + code + wr) % 4);
            run_txn(a, wr[0], e[0] ? 8'hFF : 8'h00, code, 1'b0);
          end

    // Corner: pin held low from before acceptance (R4, R7 on area 3).
    gen_pat(3);
    for (int j = 20; j < 64; j++) pat[j] = 1'b1;
    run_txn(1, 1'b1, 8'h00, 0, 1'b0);
    gen_pat(3);
    run_txn(3, 1'b1, 8'hFF, 0, 1'b0);
    gen_pat(3);
    run_txn(6, 1'b0, 8'h00, 3, 1'b0);

    // Random mix, with requests held and config scrambled while busy (R1).
    for (int t = 0; t < 300; t++) begin
      gen_pat($urandom_range(0, 3));
      run_txn($urandom_range(0, 7), 1'($urandom_range(0, 1)),
              8'($urandom_range(0, 255)), $urandom_range(0, 3),
              1'($urandom_range(0, 1)));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule